// File: doc/BRIEF.md
# Triggered Test Timing Sequencer

This block steps through a short, timed test sequence each time a host sends it a kick. The kick raises a select output, and that output tells an external pattern source to send its alternate pattern in place of the normal one. A host-programmed number of clocks later, the block gives a one-clock framework gap pulse. A fixed number of clocks after that, it gives a one-clock capture pulse, so that the response of the system under test can be read back. The select-to-gap delay sets how deep the FIFO under test runs.

The host can turn the gap pulse off without touching the pattern source. This lets a plain loop run without resynchronising. It also lets the host inject a synch error on purpose, by giving a gap when the pattern has none or by leaving out the gap when the pattern has one. A separate control bit decides whether the capture pulse is still issued while the gap is off.

The block samples all control inputs at the moment it accepts a kick. While a sequence runs, it ignores any further kick and any change to the controls, and it shows a busy flag.

Top module: `kick_seq`

## Requirements
- R1: After reset, sel_alt_o, fw_gap_o, cap_mon_o and busy_o are all 0.
- R2: If kick_i is 1 at a rising edge while busy_o is 0, then sel_alt_o is 1 for exactly SEL_LEN cycles (default 8), starting in the cycle after that edge. Call the first of these cycles cycle 0.
- R3: With gap_en_i = 1 at the kick, fw_gap_o is 1 only in cycle D, where D is gap_dly_i (5 bits, 0 to 31 clocks) sampled at the kick.
- R4: With gap_en_i = 1 at the kick, cap_mon_o is 1 only in cycle D + CAP_DLY (default 4).
- R5: With gap_en_i = 0 at the kick, fw_gap_o stays 0. In that case, cap_mon_o is 1 only in cycle D + CAP_DLY if cap_keep_i was 1 at the kick, and it stays 0 if cap_keep_i was 0.
- R6: A kick that arrives while busy_o is 1 has no effect. It neither restarts nor lengthens the running sequence.
- R7: busy_o is 1 from cycle 0 through cycle max(D + CAP_DLY, SEL_LEN - 1), and 0 in the cycle after that. A kick sampled in that cycle starts a new sequence.
- R8: Changes to gap_dly_i, gap_en_i and cap_keep_i while busy_o is 1 do not change the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | 1 | Sequence trigger, sampled on the rising edge |
| gap_dly_i | input | DLY_W | Delay from select to gap, in clocks |
| gap_en_i | input | 1 | Enables the framework gap pulse |
| cap_keep_i | input | 1 | Issues capture even when the gap is disabled |
| sel_alt_o | output | 1 | Selects the alternate pattern |
| fw_gap_o | output | 1 | Framework gap pulse |
| cap_mon_o | output | 1 | Capture-monitor-data pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions take for granted that kick_i is synchronous to clk_i and that the controls only need to be valid in the cycle a kick is accepted. The bench drives every input on the falling edge, so no input changes near a rising edge. The bench sweeps every delay value with every combination of gap enable and capture-keep. In every run it sends a stray kick and scrambles the controls partway through, and it starts each new sequence in the first idle cycle.

// File: rtl/kick_seq_pkg.sv
package kick_seq_pkg;
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/kick_seq_cfg.sv
module kick_seq_cfg #(
  parameter int unsigned DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             gap_en_i,
  input  logic             cap_keep_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             gap_en_o,
  output logic             cap_keep_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_o      <= '0;
      gap_en_o   <= 1'b0;
      cap_keep_o <= 1'b0;
    end else if (start_i) begin
      dly_o      <= dly_i;
      gap_en_o   <= gap_en_i;
      cap_keep_o <= cap_keep_i;
    end
  end
endmodule

// File: rtl/kick_seq_timer.sv
module kick_seq_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic [TW-1:0] end_i,
  output logic          start_o,
  output logic          active_o,
  output logic [TW-1:0] t_o
);
  assign start_o = kick_i & ~active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      t_o      <= '0;
    end else if (start_o) begin
      active_o <= 1'b1;
      t_o      <= '0;
    end else if (active_o) begin
      if (t_o == end_i) begin
        active_o <= 1'b0;
        t_o      <= '0;
      end else begin
        t_o <= t_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kick_seq_decode.sv
module kick_seq_decode #(
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned TW      = 6,
  parameter int unsigned CAP_DLY = 4,
  parameter int unsigned SEL_LEN = 8
) (
  input  logic             active_i,
  input  logic [TW-1:0]    t_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             gap_en_i,
  input  logic             cap_keep_i,
  output logic [TW-1:0]    end_o,
  output logic             sel_o,
  output logic             gap_o,
  output logic             cap_o
);
  localparam logic [TW-1:0] SEL_LAST = TW'(SEL_LEN - 1);

  logic [TW-1:0] gap_t, cap_t;

  always_comb begin
    gap_t = TW'(dly_i);
    cap_t = gap_t + TW'(CAP_DLY);
    end_o = (cap_t > SEL_LAST) ? cap_t : SEL_LAST;
    sel_o = active_i && (t_i <= SEL_LAST);
    gap_o = active_i && gap_en_i && (t_i == gap_t);
    cap_o = active_i && (gap_en_i || cap_keep_i) && (t_i == cap_t);
  end
endmodule

// File: rtl/kick_seq.sv
module kick_seq #(
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned CAP_DLY = 4,
  parameter int unsigned SEL_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kick_i,
  input  logic [DLY_W-1:0] gap_dly_i,
  input  logic             gap_en_i,
  input  logic             cap_keep_i,
  output logic             sel_alt_o,
  output logic             fw_gap_o,
  output logic             cap_mon_o,
  output logic             busy_o
);
  localparam int unsigned MAX_T = kick_seq_pkg::max_u((2**DLY_W) - 1 + CAP_DLY, SEL_LEN - 1);
  localparam int unsigned TW    = $clog2(MAX_T + 1);

  logic             start;
  logic             active;
  logic [TW-1:0]    t_cnt;
  logic [TW-1:0]    end_t;
  logic [DLY_W-1:0] dly_q;
  logic             gap_en_q, cap_keep_q;

  kick_seq_cfg #(.DLY_W(DLY_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .dly_i      (gap_dly_i),
    .gap_en_i   (gap_en_i),
    .cap_keep_i (cap_keep_i),
    .dly_o      (dly_q),
    .gap_en_o   (gap_en_q),
    .cap_keep_o (cap_keep_q)
  );

  kick_seq_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (kick_i),
    .end_i    (end_t),
    .start_o  (start),
    .active_o (active),
    .t_o      (t_cnt)
  );

  kick_seq_decode #(
    .DLY_W(DLY_W), .TW(TW), .CAP_DLY(CAP_DLY), .SEL_LEN(SEL_LEN)
  ) u_dec (
    .active_i   (active),
    .t_i        (t_cnt),
    .dly_i      (dly_q),
    .gap_en_i   (gap_en_q),
    .cap_keep_i (cap_keep_q),
    .end_o      (end_t),
    .sel_o      (sel_alt_o),
    .gap_o      (fw_gap_o),
    .cap_o      (cap_mon_o)
  );

  assign busy_o = active;
endmodule

// File: rtl/kick_seq_chk.sv
module kick_seq_chk #(
  parameter int unsigned CAP_DLY = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic kick_i,
  input logic sel_alt_o,
  input logic fw_gap_o,
  input logic cap_mon_o,
  input logic busy_o
);
  p_sel_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_alt_o) |-> $past(kick_i) && !$past(busy_o));

  p_gap_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_gap_o |=> !fw_gap_o);

  p_cap_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_gap_o |-> ##CAP_DLY cap_mon_o);

  p_cap_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mon_o |=> !cap_mon_o);

  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && kick_i) |=> !$rose(sel_alt_o));

  p_out_in_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_alt_o || fw_gap_o || cap_mon_o) |-> busy_o);
endmodule

bind kick_seq kick_seq_chk #(.CAP_DLY(CAP_DLY)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .kick_i    (kick_i),
  .sel_alt_o (sel_alt_o),
  .fw_gap_o  (fw_gap_o),
  .cap_mon_o (cap_mon_o),
  .busy_o    (busy_o)
);

// File: tb/kick_seq_tb_top.sv
module kick_seq_tb_top;
  localparam int DLY_W   = 5;
  localparam int CAP_DLY = 4;
  localparam int SEL_LEN = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             kick_i = 1'b0;
  logic [DLY_W-1:0] gap_dly_i = '0;
  logic             gap_en_i = 1'b0;
  logic             cap_keep_i = 1'b0;
  logic             sel_alt_o, fw_gap_o, cap_mon_o, busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  kick_seq #(.DLY_W(DLY_W), .CAP_DLY(CAP_DLY), .SEL_LEN(SEL_LEN)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kick_i     (kick_i),
    .gap_dly_i  (gap_dly_i),
    .gap_en_i   (gap_en_i),
    .cap_keep_i (cap_keep_i),
    .sel_alt_o  (sel_alt_o),
    .fw_gap_o   (fw_gap_o),
    .cap_mon_o  (cap_mon_o),
    .busy_o     (busy_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int d, input int c);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s d=%0d cyc=%0d actual=%b expected=%b", tag, d, c, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 sel", sel_alt_o, 1'b0, 0, 0);
    chk("R1 gap", fw_gap_o, 1'b0, 0, 0);
    chk("R1 cap", cap_mon_o, 1'b0, 0, 0);
    chk("R1 busy", busy_o, 1'b0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int d = 0; d < 2**DLY_W; d++) begin
      for (int m = 0; m < 4; m++) begin
        automatic logic en = m[0];
        automatic logic keep = m[1];
        automatic int last = (d + CAP_DLY > SEL_LEN - 1) ? d + CAP_DLY : SEL_LEN - 1;
        gap_dly_i  = DLY_W'(d);
        gap_en_i   = en;
        cap_keep_i = keep;
        kick_i     = 1'b1;
        @(negedge clk_i);
        kick_i = 1'b0;
        for (int c = 0; c <= last; c++) begin
          chk("R2 sel", sel_alt_o, logic'(c < SEL_LEN), d, c);
          chk(en ? "R3/R8 gap" : "R5/R8 gap", fw_gap_o, logic'(en && c == d), d, c);
          chk(en ? "R4/R8 cap" : "R5/R8 cap", cap_mon_o,
              logic'((en || keep) && c == d + CAP_DLY), d, c);
          chk("R7 busy", busy_o, 1'b1, d, c);
          if (c == 1) begin
            // R8: controls scrambled mid-run
            gap_dly_i  = ~DLY_W'(d);
            gap_en_i   = ~en;
            cap_keep_i = ~keep;
          end
          kick_i = (c == 2); // R6: stray kick while busy
          @(negedge clk_i);
        end
        kick_i = 1'b0;
        // R6/R7: run ends on time, stray kick left nothing behind
        chk("R6 sel idle", sel_alt_o, 1'b0, d, last + 1);
        chk("R6 gap idle", fw_gap_o, 1'b0, d, last + 1);
        chk("R6 cap idle", cap_mon_o, 1'b0, d, last + 1);
        chk("R7 busy low", busy_o, 1'b0, d, last + 1);
      end
    end
    done = 1'b1;
    finish_run();
  end
endmodule